// File: doc/BRIEF.md
# Hardware RTS/CTS Flow Controller

This block handles modem-line flow control for a serial port with no software involvement. It sits beside a receive FIFO, a character transmitter and the RTS/CTS pins. On the receive side it watches the FIFO fill count. It raises a receive interrupt once the count reaches the selected trigger level. It also drives the RTS pin with hysteresis: RTS goes off at a level above the trigger and comes back on only after the FIFO has drained well below it. The FIFO keeps taking characters while RTS is off, up to its capacity.

On the transmit side it synchronizes the CTS input. When the far end raises CTS, the block lets the character in flight finish and then pauses the transmitter. A change on CTS in either direction can also latch a status flag, which software clears with a pulse.

The design has two state machines. The RTS machine has the states `RTS_OFF` (pin high) and `RTS_ON` (pin low). Its transitions are:
- OFF→ON when auto-RTS is enabled and the fill count is at or below the resume level.
- ON→OFF when the fill count reaches the halt level, or when auto-RTS is disabled.

The transmit gate has the states `TX_RUN`, `TX_DRAIN` and `TX_HOLD`. Its transitions are:
- RUN→DRAIN when CTS is high with auto-CTS enabled.
- RUN→HOLD or DRAIN→HOLD on the stop-bit strobe while that stop request holds.
- DRAIN→RUN or HOLD→RUN when CTS falls or auto-CTS is disabled.

Top module: `hw_flow_ctrl`

## Requirements
- R1: While reset is asserted and after its release until inputs act, `rts_n` is 1, and `tx_pause`, `rx_trig_irq` and `cts_chg_flag` are 0.
- R2: `trig_sel` values 0, 1, 2 and 3 select trigger levels of 8, 16, 24 and 28 characters. `rx_trig_irq` is 1 in the cycle after any clock edge where `rx_fill` is at or above the selected level, and 0 otherwise.
- R3: With `rts_auto_en`=1, `rts_n` becomes 1 one cycle after `rx_fill` reaches the halt level. The halt level is 16, 24, 28 or 28 for `trig_sel` 0 to 3.
- R4: With `rts_auto_en`=1, `rts_n` becomes 0 one cycle after `rx_fill` is at or below the resume level. The resume level is 0, 7, 15 or 23 for `trig_sel` 0 to 3. Between the resume and halt levels, `rts_n` keeps its value.
- R5: With `rts_auto_en`=0, `rts_n` is 1 one cycle later, whatever the fill count.
- R6: With `cts_auto_en`=1 and CTS high, `tx_pause` stays 0 until a `tx_stop_done` pulse. It rises in the cycle after that pulse is sampled, once the synchronized CTS is high. CTS passes through two synchronizer flops before use.
- R7: After `cts_in` returns to 0, `tx_pause` falls three clock edges later.
- R8: With `cts_auto_en`=0, `tx_pause` is 0 one cycle later, and CTS has no effect on it.
- R9: Either edge of `cts_in` sets `cts_chg_flag` three clock edges later, but only if `cts_irq_en` is 1 at that edge. With `cts_irq_en`=0, the flag is not set.
- R10: `cts_chg_flag` stays set until a `cts_flag_clr` pulse clears it. A new change in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_fill | input | FILL_W | Receive FIFO character count |
| trig_sel | input | 2 | Trigger level select |
| rts_auto_en | input | 1 | Enables automatic RTS |
| cts_auto_en | input | 1 | Enables automatic CTS |
| cts_in | input | 1 | CTS pin (1 = stop) |
| cts_irq_en | input | 1 | Enables the CTS change flag |
| cts_flag_clr | input | 1 | Clear pulse for the CTS change flag |
| tx_stop_done | input | 1 | Strobe: stop bit of current character shifted out |
| rts_n | output | 1 | RTS pin (0 = ready to receive) |
| tx_pause | output | 1 | Transmitter must hold |
| rx_trig_irq | output | 1 | Receive trigger level reached |
| cts_chg_flag | output | 1 | Latched CTS change status |

## Verification
The RTS and receive-interrupt outputs are registered once, so they are due one edge after a fill or select change. Any CTS edge needs two synchronizer edges plus one state edge, so the pause and flag responses to CTS are due three edges later. A pause caused by `tx_stop_done` is due one edge after the strobe. The bench drives inputs at falling edges and holds a behavioural model with the same per-edge latencies. It compares every output at each falling edge and adds directed checks that count exactly those edges before sampling.

// File: rtl/hwfc_pkg.sv
package hwfc_pkg;

    typedef enum logic {
        RTS_OFF,
        RTS_ON
    } rts_state_e;

    typedef enum logic [1:0] {
        TX_RUN,
        TX_DRAIN,
        TX_HOLD
    } tx_state_e;

    // Receive interrupt threshold per select code
    function automatic int unsigned trig_level(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 8;
            2'd1:    return 16;
            2'd2:    return 24;
            default: return 28;
        endcase
    endfunction

    // RTS goes off at the next level up (top level saturates)
    function automatic int unsigned halt_level(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 16;
            2'd1:    return 24;
            default: return 28;
        endcase
    endfunction

    // RTS comes back once fill drains to this level
    function automatic int unsigned resume_level(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 0;
            2'd1:    return 7;
            2'd2:    return 15;
            default: return 23;
        endcase
    endfunction

endpackage

// File: rtl/hwfc_sync.sv
module hwfc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic chg
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                chain[i] <= chain[i-1];
            end
            chain[0] <= d;
            prev     <= chain[STAGES-1];
        end
    end

    assign q   = chain[STAGES-1];
    assign chg = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/hwfc_rts_fsm.sv
module hwfc_rts_fsm
    import hwfc_pkg::*;
#(
    parameter int FILL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [FILL_W-1:0] fill,
    input  logic [1:0]        sel,
    output logic              rts_n
);
    rts_state_e state, state_nx;
    logic       at_halt, at_resume;

    assign at_halt   = 32'(fill) >= halt_level(sel);
    assign at_resume = 32'(fill) <= resume_level(sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RTS_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RTS_OFF: if (en && at_resume)  state_nx = RTS_ON;
            RTS_ON:  if (!en || at_halt)   state_nx = RTS_OFF;
            default:                       state_nx = RTS_OFF;
        endcase
    end

    always_comb begin
        rts_n = (state != RTS_ON);
    end
endmodule

// File: rtl/hwfc_tx_gate.sv
module hwfc_tx_gate
    import hwfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cts_stop,
    input  logic stop_done,
    output logic pause
);
    tx_state_e state, state_nx;
    logic      hold_req;

    assign hold_req = en && cts_stop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_RUN: begin
                if (hold_req) state_nx = stop_done ? TX_HOLD : TX_DRAIN;
            end
            TX_DRAIN: begin
                if (!hold_req)      state_nx = TX_RUN;
                else if (stop_done) state_nx = TX_HOLD;
            end
            TX_HOLD: begin
                if (!hold_req) state_nx = TX_RUN;
            end
            default: state_nx = TX_RUN;
        endcase
    end

    always_comb begin
        pause = (state == TX_HOLD);
    end
endmodule

// File: rtl/hw_flow_ctrl.sv
module hw_flow_ctrl
    import hwfc_pkg::*;
#(
    parameter int FILL_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] rx_fill,
    input  logic [1:0]        trig_sel,
    input  logic              rts_auto_en,
    input  logic              cts_auto_en,
    input  logic              cts_in,
    input  logic              cts_irq_en,
    input  logic              cts_flag_clr,
    input  logic              tx_stop_done,
    output logic              rts_n,
    output logic              tx_pause,
    output logic              rx_trig_irq,
    output logic              cts_chg_flag
);
    logic cts_s;
    logic cts_chg;

    hwfc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (cts_in),
        .q    (cts_s),
        .chg  (cts_chg)
    );

    hwfc_rts_fsm #(.FILL_W(FILL_W)) u_rts (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (rts_auto_en),
        .fill (rx_fill),
        .sel  (trig_sel),
        .rts_n(rts_n)
    );

    hwfc_tx_gate u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cts_auto_en),
        .cts_stop (cts_s),
        .stop_done(tx_stop_done),
        .pause    (tx_pause)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_trig_irq  <= 1'b0;
            cts_chg_flag <= 1'b0;
        end else begin
            rx_trig_irq <= 32'(rx_fill) >= trig_level(trig_sel);
            if (cts_chg && cts_irq_en) cts_chg_flag <= 1'b1;
            else if (cts_flag_clr)     cts_chg_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/hwfc_checker.sv
module hwfc_checker
    import hwfc_pkg::*;
#(
    parameter int FILL_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FILL_W-1:0] rx_fill,
    input logic [1:0]        trig_sel,
    input logic              rts_auto_en,
    input logic              cts_auto_en,
    input logic              cts_in,
    input logic              cts_irq_en,
    input logic              cts_flag_clr,
    input logic              tx_stop_done,
    input logic              rts_n,
    input logic              tx_pause,
    input logic              rx_trig_irq,
    input logic              cts_chg_flag
);
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_state_r1: assert (rts_n && !tx_pause && !rx_trig_irq && !cts_chg_flag)
                else $error("reset state violated");
        end
    end

    p_irq_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rx_fill) >= trig_level(trig_sel)) |=> rx_trig_irq);

    p_irq_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rx_fill) < trig_level(trig_sel)) |=> !rx_trig_irq);

    p_rts_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_auto_en && 32'(rx_fill) >= halt_level(trig_sel)) |=> rts_n);

    p_rts_resume_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_auto_en && 32'(rx_fill) <= resume_level(trig_sel)) |=> !rts_n);

    p_rts_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_auto_en && 32'(rx_fill) > resume_level(trig_sel)
         && 32'(rx_fill) < halt_level(trig_sel)) |=> $stable(rts_n));

    p_rts_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_auto_en |=> rts_n);

    p_pause_on_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_pause) |-> ($past(tx_stop_done) && $past(cts_auto_en)));

    p_pause_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cts_auto_en |=> !tx_pause);

    p_flag_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cts_chg_flag) |-> $past(cts_irq_en));

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_chg_flag && !cts_flag_clr) |=> cts_chg_flag);
endmodule

bind hw_flow_ctrl hwfc_checker #(.FILL_W(FILL_W)) u_chk (.*);

// File: tb/test_hw_flow_ctrl.sv
`timescale 1ns/1ps
module test_hw_flow_ctrl;
    localparam int FW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FW-1:0] rx_fill = '0;
    logic [1:0]    trig_sel = 2'd0;
    logic          rts_auto_en = 1'b0;
    logic          cts_auto_en = 1'b0;
    logic          cts_in = 1'b0;
    logic          cts_irq_en = 1'b0;
    logic          cts_flag_clr = 1'b0;
    logic          tx_stop_done = 1'b0;
    logic          rts_n, tx_pause, rx_trig_irq, cts_chg_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hw_flow_ctrl #(.FILL_W(FW)) i_hw_flow_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .trig_sel(trig_sel),
        .rts_auto_en(rts_auto_en), .cts_auto_en(cts_auto_en), .cts_in(cts_in),
        .cts_irq_en(cts_irq_en), .cts_flag_clr(cts_flag_clr),
        .tx_stop_done(tx_stop_done), .rts_n(rts_n), .tx_pause(tx_pause),
        .rx_trig_irq(rx_trig_irq), .cts_chg_flag(cts_chg_flag)
    );

    // Reference tables from the requirements
    function automatic int lvl_trig(int s);
        int t[4] = '{8, 16, 24, 28};
        return t[s];
    endfunction
    function automatic int lvl_halt(int s);
        int t[4] = '{16, 24, 28, 28};
        return t[s];
    endfunction
    function automatic int lvl_res(int s);
        int t[4] = '{0, 7, 15, 23};
        return t[s];
    endfunction

    // Behavioural model: CTS history, and expected outputs
    int cts_hist[$];
    int m_rts = 1, m_pause = 0, m_irq = 0, m_flag = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            cts_hist = '{0, 0, 0};
            m_rts = 1; m_pause = 0; m_irq = 0; m_flag = 0;
        end else begin
            int seen, older, f;
            seen  = cts_hist[1];   // CTS after two sync edges
            older = cts_hist[2];
            f     = int'(rx_fill);
            m_irq = (f >= lvl_trig(int'(trig_sel))) ? 1 : 0;
            if (!rts_auto_en)                                        m_rts = 1;
            else if (m_rts == 0 && f >= lvl_halt(int'(trig_sel)))   m_rts = 1;
            else if (m_rts == 1 && f <= lvl_res(int'(trig_sel)))    m_rts = 0;
            m_pause = (cts_auto_en && seen == 1 && (m_pause == 1 || tx_stop_done)) ? 1 : 0;
            if (cts_irq_en && seen != older) m_flag = 1;
            else if (cts_flag_clr)           m_flag = 0;
            void'(cts_hist.pop_back());
            cts_hist.push_front(int'(cts_in));
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R3/R4/R5", "model rts_n", int'(rts_n), m_rts);
            chk("R6/R7/R8", "model tx_pause", int'(tx_pause), m_pause);
            chk("R2", "model rx_trig_irq", int'(rx_trig_irq), m_irq);
            chk("R9/R10", "model cts_chg_flag", int'(cts_chg_flag), m_flag);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        step(3);
        chk("R1", "reset rts_n", int'(rts_n), 1);
        chk("R1", "reset tx_pause", int'(tx_pause), 0);
        chk("R1", "reset irq", int'(rx_trig_irq), 0);
        chk("R1", "reset flag", int'(cts_chg_flag), 0);
        rst_n = 1'b1;
        step(1);
        chk("R1", "post-reset rts_n with auto off", int'(rts_n), 1);

        // RTS hysteresis, select 0 (8 / halt 16 / resume 0)
        rts_auto_en = 1'b1; rx_fill = 0;      step(1);
        chk("R4", "sel0 fill0 rts_n", int'(rts_n), 0);
        rx_fill = 15;                         step(2);
        chk("R4", "sel0 fill15 hold", int'(rts_n), 0);
        chk("R2", "sel0 fill15 irq", int'(rx_trig_irq), 1);
        rx_fill = 16;                         step(1);
        chk("R3", "sel0 fill16 rts_n", int'(rts_n), 1);
        rx_fill = 5;                          step(1);
        chk("R4", "sel0 fill5 hold off", int'(rts_n), 1);
        chk("R2", "sel0 fill5 irq", int'(rx_trig_irq), 0);
        rx_fill = 0;                          step(1);
        chk("R4", "sel0 fill0 resume", int'(rts_n), 0);

        // select 3 (28 / halt 28 / resume 23)
        trig_sel = 2'd3; rx_fill = 27;        step(1);
        chk("R2", "sel3 fill27 irq", int'(rx_trig_irq), 0);
        chk("R3", "sel3 fill27 rts_n", int'(rts_n), 0);
        rx_fill = 28;                         step(1);
        chk("R2", "sel3 fill28 irq", int'(rx_trig_irq), 1);
        chk("R3", "sel3 fill28 rts_n", int'(rts_n), 1);
        rx_fill = 24;                         step(1);
        chk("R4", "sel3 fill24 hold", int'(rts_n), 1);
        rx_fill = 23;                         step(1);
        chk("R4", "sel3 fill23 resume", int'(rts_n), 0);

        // select 1 (16 / halt 24 / resume 7)
        trig_sel = 2'd1; rx_fill = 16;        step(1);
        chk("R2", "sel1 fill16 irq", int'(rx_trig_irq), 1);
        chk("R4", "sel1 fill16 hold on", int'(rts_n), 0);
        rx_fill = 24;                         step(1);
        chk("R3", "sel1 fill24 rts_n", int'(rts_n), 1);
        rx_fill = 8;                          step(1);
        chk("R4", "sel1 fill8 hold", int'(rts_n), 1);
        rx_fill = 7;                          step(1);
        chk("R4", "sel1 fill7 resume", int'(rts_n), 0);

        // auto-RTS disabled
        rts_auto_en = 1'b0; rx_fill = 0;      step(1);
        chk("R5", "disabled rts_n", int'(rts_n), 1);
        rts_auto_en = 1'b1;                   step(1);

        // CTS pause on character boundary
        cts_auto_en = 1'b1; cts_irq_en = 1'b1;
        cts_in = 1'b1;                        step(3);
        chk("R9", "flag after rise", int'(cts_chg_flag), 1);
        chk("R6", "no pause before stop", int'(tx_pause), 0);
        step(3);
        chk("R6", "still no pause", int'(tx_pause), 0);
        chk("R10", "flag held", int'(cts_chg_flag), 1);
        tx_stop_done = 1'b1;                  step(1);
        tx_stop_done = 1'b0;
        chk("R6", "pause after stop", int'(tx_pause), 1);
        cts_flag_clr = 1'b1;                  step(1);
        cts_flag_clr = 1'b0;
        chk("R10", "flag cleared", int'(cts_chg_flag), 0);
        cts_in = 1'b0;                        step(2);
        chk("R7", "pause held during sync", int'(tx_pause), 1);
        step(1);
        chk("R7", "pause released", int'(tx_pause), 0);
        chk("R9", "flag on fall", int'(cts_chg_flag), 1);
        cts_flag_clr = 1'b1;                  step(1);
        cts_flag_clr = 1'b0;

        // auto-CTS disabled
        cts_auto_en = 1'b0; cts_in = 1'b1;    step(4);
        tx_stop_done = 1'b1;                  step(1);
        tx_stop_done = 1'b0;                  step(1);
        chk("R8", "no pause when disabled", int'(tx_pause), 0);
        cts_auto_en = 1'b1; tx_stop_done = 1'b1; step(1);
        tx_stop_done = 1'b0;
        chk("R6", "pause immediate on stop", int'(tx_pause), 1);
        cts_auto_en = 1'b0;                   step(1);
        chk("R8", "pause dropped on disable", int'(tx_pause), 0);

        // flag enable off
        cts_flag_clr = 1'b1;                  step(1);
        cts_flag_clr = 1'b0; cts_irq_en = 1'b0;
        cts_in = 1'b0;                        step(4);
        chk("R9", "no flag when disabled", int'(cts_chg_flag), 0);

        // Random phase against the model
        cts_auto_en = 1'b1; cts_irq_en = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 45 && rx_fill < 6'd32)      rx_fill = rx_fill + 1'b1;
            else if (r < 90 && rx_fill > 6'd0)  rx_fill = rx_fill - 1'b1;
            if ($urandom_range(0, 63) == 0)  trig_sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 15) == 0)  cts_in = ~cts_in;
            if ($urandom_range(0, 127) == 0) rts_auto_en = ~rts_auto_en;
            if ($urandom_range(0, 127) == 0) cts_auto_en = ~cts_auto_en;
            if ($urandom_range(0, 63) == 0)  cts_irq_en = ~cts_irq_en;
            cts_flag_clr = ($urandom_range(0, 9) == 0);
            tx_stop_done = ($urandom_range(0, 7) == 0);
            step(1);
        end
        cts_flag_clr = 1'b0; tx_stop_done = 1'b0;
        step(2);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule